// File: doc/BRIEF.md
# Multi-Source Capture Trigger Detector

This block decides on which sample a data capture begins. It evaluates one of four selectable event sources on every valid sample: a software bit, an external pin, a level crossing of the signed real converter word, and a level crossing of the squared magnitude of a complex baseband sample (I²+Q²). The magnitude is compared in the squared domain, so neither a square root nor a logarithm is needed. The two level sources use hysteresis. The signal must first leave a band on the far side of the level before a crossing can count, so noise around the level cannot fire on the wrong slope.

Several units share one active-low, open-drain sync line. A unit that detects its own event pulls the line low. Every armed unit, including the one that pulled it, fires on the first valid sample on which it sees the line low. All units therefore start on the same sample. A unit set as follower never pulls the line and only reacts to it. After firing, a unit ignores all events until its arm input is dropped and raised again.

The controller has five states. IDLE waits for arm. ARMED watches for a local event and for the line. DRIVE pulls the line low. FIRE is the single pulse cycle. HOLD waits for arm to drop. The transitions are:
- arm-up: IDLE to ARMED, when arm is high.
- local-event: ARMED to DRIVE, on a valid sample with a selected event in leader mode.
- line-seen: ARMED or DRIVE to FIRE, on a valid sample with the line low.
- disarm: ARMED or DRIVE to IDLE, when arm is low. Disarm takes priority over the other transitions.
- done: FIRE to HOLD, unconditionally.
- release: HOLD to IDLE, when arm is low.

Top module: `capture_trigger`

## Requirements
- R1: `cfg_src` selects the event source: 0 software bit, 1 external pin, 2 converter level, 3 magnitude level. Events from the sources that are not selected have no effect.
- R2: `cfg_falling` selects the slope (0 rising, 1 falling). For the two bit sources, an event is a change of the bit between the previous valid sample and the current valid sample. The remembered bit value is 0 after reset.
- R3: Converter level, rising slope. A valid sample below `cfg_adc_level - cfg_adc_hyst` primes the detector. The first later valid sample at or above `cfg_adc_level` is an event, and the event clears the priming. Without priming, no event occurs.
- R4: Converter level, falling slope. A valid sample above `cfg_adc_level + cfg_adc_hyst` primes the detector. The first later valid sample at or below the level is an event. Priming is the mirror image of R3.
- R5: The magnitude source applies the R3 and R4 rules to I²+Q², using the squared level `cfg_mag_level` and the band `cfg_mag_hyst`.
- R6: The external pin passes through two flops. A pin change made just before clock edge k takes effect in event detection at edge k+2.
- R7: A leader unit (`cfg_follow`=0) that sees a local event at a clock edge while ARMED drives `sync_drive_low` high from that edge. It keeps driving until it fires or is disarmed.
- R8: When a valid sample sees `sync_in` low while the unit is armed in ARMED or DRIVE, `trig_pulse` is high for exactly the one cycle after that clock edge.
- R9: A follower unit (`cfg_follow`=1) never drives the line, but fires from the line as in R8.
- R10: While `arm` is low, and after firing until `arm` has been low and is raised again, the unit produces no pulse and does not drive the line.
- R11: During and right after reset, `trig_pulse` and `sync_drive_low` are low and the unit is in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | Marks a clock with a valid sample |
| adc_smp | input | ADC_W | Signed real converter word |
| bb_i | input | IQ_W | Signed in-phase baseband word |
| bb_q | input | IQ_W | Signed quadrature baseband word |
| ext_pin | input | 1 | Asynchronous external trigger pin |
| sw_trig | input | 1 | Software trigger bit |
| arm | input | 1 | Arms the unit when high |
| cfg_src | input | 2 | Source select (see R1) |
| cfg_falling | input | 1 | Slope select, 1 = falling |
| cfg_follow | input | 1 | Follower mode, 1 = never drives the line |
| cfg_adc_level | input | ADC_W | Signed converter level |
| cfg_adc_hyst | input | ADC_W | Unsigned converter hysteresis band |
| cfg_mag_level | input | 2*IQ_W | Unsigned squared magnitude level |
| cfg_mag_hyst | input | 2*IQ_W | Unsigned squared magnitude band |
| sync_in | input | 1 | Sensed level of the shared line, low = asserted |
| trig_pulse | output | 1 | One-cycle capture start |
| sync_drive_low | output | 1 | Pulls the shared line low when high |

## Verification
The assertions assume that the configuration inputs stay constant while the unit is armed. They also assume that `sync_in` reflects the wired-AND of this unit's own drive with its peers, so that a unit in DRIVE sees the line low. The bench models the line as the inverse of the OR of `sync_drive_low` and an emulated peer. It changes the configuration only while `smp_vld` is low, before the unit is armed. All inputs change half a cycle away from the sampling edge.

// File: rtl/capture_trigger_pkg.sv
package capture_trigger_pkg;

    typedef enum logic [1:0] {
        SRC_SOFT = 2'd0,
        SRC_EXT  = 2'd1,
        SRC_ADC  = 2'd2,
        SRC_MAG  = 2'd3
    } trig_src_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_DRIVE = 3'd2,
        ST_FIRE  = 3'd3,
        ST_HOLD  = 3'd4
    } trig_state_e;

endpackage

// File: rtl/trig_bit_edge.sv
module trig_bit_edge #(
    parameter int SYNC_STAGES = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_vld,
    input  logic falling,
    input  logic bit_in,
    output logic evt
);
    logic cur;
    logic prev_q;

    generate
        if (SYNC_STAGES > 0) begin : g_sync
            logic [SYNC_STAGES-1:0] sync_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], bit_in};
            end
            assign cur = sync_q[SYNC_STAGES-1];
        end else begin : g_direct
            assign cur = bit_in;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       prev_q <= 1'b0;
        else if (smp_vld) prev_q <= cur;
    end

    assign evt = smp_vld & (falling ? (prev_q & ~cur) : (~prev_q & cur));

    AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> (prev_q != cur)) else $error("edge without change"); // R2

endmodule

// File: rtl/trig_hyst_det.sv
module trig_hyst_det #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_vld,
    input  logic                falling,
    input  logic signed [W-1:0] value,
    input  logic signed [W-1:0] level,
    input  logic        [W-1:0] hyst,
    output logic                evt
);
    localparam int XW = W + 2;

    logic signed [XW-1:0] xv, xl, xh, band_lo, band_hi;
    logic                 crossed, prime_c, primed_q;

    assign xv      = XW'(value);
    assign xl      = XW'(level);
    assign xh      = signed'({2'b00, hyst});
    assign band_lo = xl - xh;
    assign band_hi = xl + xh;

    assign crossed = falling ? (xv <= xl) : (xv >= xl);
    assign prime_c = falling ? (xv > band_hi) : (xv < band_lo);
    assign evt     = smp_vld & primed_q & crossed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        primed_q <= 1'b0;
        else if (evt)      primed_q <= 1'b0;
        else if (smp_vld && prime_c) primed_q <= 1'b1;
    end

    AST_EVT_CLEARS_PRIME: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !primed_q) else $error("priming kept after event"); // R3
    AST_PRIME_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(primed_q) |-> $past(smp_vld)) else $error("primed without sample"); // R4

endmodule

// File: rtl/capture_trigger.sv
module capture_trigger
    import capture_trigger_pkg::*;
#(
    parameter int ADC_W = 16,
    parameter int IQ_W  = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  smp_vld,
    input  logic signed [ADC_W-1:0] adc_smp,
    input  logic signed [IQ_W-1:0]  bb_i,
    input  logic signed [IQ_W-1:0]  bb_q,
    input  logic                  ext_pin,
    input  logic                  sw_trig,
    input  logic                  arm,
    input  logic [1:0]            cfg_src,
    input  logic                  cfg_falling,
    input  logic                  cfg_follow,
    input  logic signed [ADC_W-1:0] cfg_adc_level,
    input  logic [ADC_W-1:0]      cfg_adc_hyst,
    input  logic [2*IQ_W-1:0]     cfg_mag_level,
    input  logic [2*IQ_W-1:0]     cfg_mag_hyst,
    input  logic                  sync_in,
    output logic                  trig_pulse,
    output logic                  sync_drive_low
);
    localparam int SQ_W  = 2 * IQ_W;
    localparam int MAG_W = SQ_W + 1;

    logic                    sw_evt, ext_evt, adc_evt, mag_evt, local_evt;
    logic signed [SQ_W-1:0]  i_ext, q_ext, i_sq, q_sq;
    logic        [SQ_W-1:0]  mag_sq;
    trig_state_e             state_q, state_d;

    // bit sources
    trig_bit_edge #(.SYNC_STAGES(0)) u_sw_edge (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
        .falling(cfg_falling), .bit_in(sw_trig), .evt(sw_evt));

    trig_bit_edge #(.SYNC_STAGES(2)) u_ext_edge (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
        .falling(cfg_falling), .bit_in(ext_pin), .evt(ext_evt));

    // level sources
    trig_hyst_det #(.W(ADC_W)) u_adc_det (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .falling(cfg_falling),
        .value(adc_smp), .level(cfg_adc_level), .hyst(cfg_adc_hyst),
        .evt(adc_evt));

    assign i_ext  = SQ_W'(bb_i);
    assign q_ext  = SQ_W'(bb_q);
    assign i_sq   = i_ext * i_ext;
    assign q_sq   = q_ext * q_ext;
    assign mag_sq = $unsigned(i_sq) + $unsigned(q_sq);

    trig_hyst_det #(.W(MAG_W)) u_mag_det (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .falling(cfg_falling),
        .value(signed'({1'b0, mag_sq})), .level(signed'({1'b0, cfg_mag_level})),
        .hyst({1'b0, cfg_mag_hyst}), .evt(mag_evt));

    always_comb begin
        unique case (trig_src_e'(cfg_src))
            SRC_SOFT: local_evt = sw_evt;
            SRC_EXT:  local_evt = ext_evt;
            SRC_ADC:  local_evt = adc_evt;
            SRC_MAG:  local_evt = mag_evt;
            default:  local_evt = 1'b0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (arm) state_d = ST_ARMED;
            ST_ARMED: begin
                if (!arm)                       state_d = ST_IDLE;
                else if (smp_vld && !sync_in)   state_d = ST_FIRE;
                else if (local_evt && !cfg_follow) state_d = ST_DRIVE;
            end
            ST_DRIVE: begin
                if (!arm)                       state_d = ST_IDLE;
                else if (smp_vld && !sync_in)   state_d = ST_FIRE;
            end
            ST_FIRE:  state_d = ST_HOLD;
            ST_HOLD:  if (!arm) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        trig_pulse     = (state_q == ST_FIRE);
        sync_drive_low = (state_q == ST_DRIVE);
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |=> !trig_pulse) else $error("pulse longer than one cycle"); // R8
    AST_PULSE_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> $past(smp_vld && !sync_in && arm)) else $error("pulse without line"); // R8
    AST_DRIVE_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_drive_low) |-> $past(local_evt && !cfg_follow && arm)) else $error("drive without event"); // R7
    AST_FOLLOWER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_follow) && !$past(sync_drive_low)) |-> !sync_drive_low) else $error("follower drove line"); // R9
    AST_UNARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(arm) |-> (!trig_pulse && !sync_drive_low)) else $error("activity while unarmed"); // R10

endmodule

// File: tb/test_capture_trigger.sv
`timescale 1ns/1ps
module test_capture_trigger;
    localparam int ADC_W = 16;
    localparam int IQ_W  = 12;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0, smp_vld = 1'b0, ext_pin = 1'b0, sw_trig = 1'b0, arm = 1'b0;
    logic signed [ADC_W-1:0] adc_smp = '0, cfg_adc_level = '0;
    logic signed [IQ_W-1:0]  bb_i = '0, bb_q = '0;
    logic [1:0]  cfg_src = 2'd0;
    logic        cfg_falling = 1'b0, cfg_follow = 1'b0, peer_low = 1'b0;
    logic [ADC_W-1:0]  cfg_adc_hyst = '0;
    logic [2*IQ_W-1:0] cfg_mag_level = '0, cfg_mag_hyst = '0;
    logic trig_pulse, sync_drive_low, sync_in;

    assign sync_in = !(sync_drive_low || peer_low);

    capture_trigger #(.ADC_W(ADC_W), .IQ_W(IQ_W)) i_capture_trigger (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .adc_smp(adc_smp),
        .bb_i(bb_i), .bb_q(bb_q), .ext_pin(ext_pin), .sw_trig(sw_trig),
        .arm(arm), .cfg_src(cfg_src), .cfg_falling(cfg_falling),
        .cfg_follow(cfg_follow), .cfg_adc_level(cfg_adc_level),
        .cfg_adc_hyst(cfg_adc_hyst), .cfg_mag_level(cfg_mag_level),
        .cfg_mag_hyst(cfg_mag_hyst), .sync_in(sync_in),
        .trig_pulse(trig_pulse), .sync_drive_low(sync_drive_low));

    int checks = 0, fails = 0, npulse = 0;
    string req = "R11";
    bit finished = 0;

    // reference model: 0 idle, 1 armed, 2 drive, 3 fire, 4 hold
    int  mst = 0;
    bit  m_prev_sw = 0, m_prev_ext = 0, m_adc_pr = 0, m_mag_pr = 0;
    bit  ext_q[$] = '{0, 0};

    task automatic chk(string r, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
        end
    endtask

    function automatic bit lvl_evt(bit fall, bit primed, longint v, longint l);
        return primed && (fall ? (v <= l) : (v >= l));
    endfunction

    function automatic bit lvl_prime(bit fall, longint v, longint l, longint h);
        return fall ? (v > l + h) : (v < l - h);
    endfunction

    task automatic step();
        bit line_low, cur_ext, sw_e, ext_e, adc_e, mag_e, loc;
        longint av, mv;
        @(posedge clk);
        line_low = (mst == 2) || peer_low;
        cur_ext  = ext_q[0];
        av = adc_smp;
        mv = longint'(bb_i) * bb_i + longint'(bb_q) * bb_q;
        sw_e  = smp_vld && (cfg_falling ? (m_prev_sw && !sw_trig) : (!m_prev_sw && sw_trig));
        ext_e = smp_vld && (cfg_falling ? (m_prev_ext && !cur_ext) : (!m_prev_ext && cur_ext));
        adc_e = smp_vld && lvl_evt(cfg_falling, m_adc_pr, av, cfg_adc_level);
        mag_e = smp_vld && lvl_evt(cfg_falling, m_mag_pr, mv, longint'(cfg_mag_level));
        if (smp_vld) begin
            m_prev_sw  = sw_trig;
            m_prev_ext = cur_ext;
            if (adc_e) m_adc_pr = 0;
            else if (lvl_prime(cfg_falling, av, cfg_adc_level, longint'(cfg_adc_hyst))) m_adc_pr = 1;
            if (mag_e) m_mag_pr = 0;
            else if (lvl_prime(cfg_falling, mv, longint'(cfg_mag_level), longint'(cfg_mag_hyst))) m_mag_pr = 1;
        end
        case (cfg_src)
            2'd0: loc = sw_e;
            2'd1: loc = ext_e;
            2'd2: loc = adc_e;
            default: loc = mag_e;
        endcase
        case (mst)
            0: if (arm) mst = 1;
            1, 2: begin
                if (!arm) mst = 0;
                else if (smp_vld && line_low) mst = 3;
                else if (mst == 1 && loc && !cfg_follow) mst = 2;
            end
            3: mst = 4;
            default: if (!arm) mst = 0;
        endcase
        void'(ext_q.pop_front());
        ext_q.push_back(ext_pin);
        @(negedge clk);
        chk(req, "trig_pulse", trig_pulse, mst == 3);
        chk(req, "sync_drive_low", sync_drive_low, mst == 2);
        if (trig_pulse) npulse++;
    endtask

    task automatic steps(int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic adc_smp_put(int v);
        adc_smp = ADC_W'(v); smp_vld = 1; step();
    endtask

    task automatic mag_put(int i, int q);
        bb_i = IQ_W'(i); bb_q = IQ_W'(q); smp_vld = 1; step();
    endtask

    task automatic rearm();
        smp_vld = 0; arm = 0; steps(2); arm = 1; step(); npulse = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not end actual=1 expected=0");
        finish_run();
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "pulse in reset", trig_pulse, 0);
        chk("R11", "drive in reset", sync_drive_low, 0);
        rst_n = 1;
        steps(2);

        // R8, R2: software rising, latency two valid samples
        req = "R8"; rearm();
        smp_vld = 1; sw_trig = 1;
        cyc = 0;
        while (!trig_pulse && cyc < 10) begin step(); cyc++; end
        chk("R8", "software event to pulse cycles", cyc, 2);
        step();
        chk("R8", "pulse width", trig_pulse, 0);

        // R10: ignored after firing until rearm
        req = "R10"; npulse = 0;
        sw_trig = 0; step(); sw_trig = 1; step(); steps(3);
        chk("R10", "pulses while holding", npulse, 0);

        // R2: software falling
        req = "R2"; cfg_falling = 1; rearm();
        smp_vld = 1; sw_trig = 1; step(); step();
        chk("R2", "no fire on rising when falling", npulse, 0);
        sw_trig = 0; steps(3);
        chk("R2", "fire on falling", npulse, 1);

        // R6: external pin latency through synchronizer
        req = "R6"; cfg_falling = 0; cfg_src = 2'd1; rearm();
        smp_vld = 1; steps(2);
        ext_pin = 1; cyc = 0;
        while (!trig_pulse && cyc < 12) begin step(); cyc++; end
        chk("R6", "pin change to pulse cycles", cyc, 4);

        // R3: converter rising with hysteresis
        req = "R3"; smp_vld = 0; cfg_src = 2'd2; cfg_adc_level = 16'sd1000; cfg_adc_hyst = 16'd200;
        rearm();
        adc_smp_put(1500); adc_smp_put(900); adc_smp_put(1200);
        chk("R3", "no fire without priming", npulse, 0);
        adc_smp_put(700); adc_smp_put(950); adc_smp_put(850);
        smp_vld = 0; adc_smp = 16'sd2000; steps(2);
        chk("R3", "invalid sample ignored", npulse, 0);
        adc_smp_put(1000); adc_smp_put(1000); steps(2);
        chk("R3", "fire at level", npulse, 1);

        // R4: converter falling
        req = "R4"; smp_vld = 0; cfg_falling = 1; cfg_adc_level = -16'sd500; cfg_adc_hyst = 16'd100;
        rearm();
        adc_smp_put(-450); adc_smp_put(-499);
        chk("R4", "no fire without priming", npulse, 0);
        adc_smp_put(-300); adc_smp_put(-450); adc_smp_put(-500); adc_smp_put(-500); steps(1);
        chk("R4", "fire at level falling", npulse, 1);

        // R5: magnitude rising in squared domain
        req = "R5"; smp_vld = 0; cfg_falling = 0; cfg_src = 2'd3;
        cfg_mag_level = 24'd10000; cfg_mag_hyst = 24'd3000; rearm();
        mag_put(120, 0);
        chk("R5", "no fire without priming", npulse, 0);
        mag_put(50, 50); mag_put(70, 70);
        chk("R5", "no fire below level", npulse, 0);
        mag_put(-80, 60); mag_put(-80, 60); steps(1);
        chk("R5", "fire at squared level", npulse, 1);

        // R1: unselected sources have no effect
        req = "R1"; smp_vld = 0; cfg_src = 2'd2; cfg_falling = 1;
        bb_i = 0; bb_q = 0; rearm();
        adc_smp_put(0);
        sw_trig = 0; step(); sw_trig = 1; step();
        ext_pin = 0; steps(4); ext_pin = 1; steps(4);
        chk("R1", "unselected sources ignored", npulse, 0);
        adc_smp_put(-600); steps(2);
        chk("R1", "selected source still fires", npulse, 1);

        // R7: drive held without valid sample, dropped on disarm
        req = "R7"; smp_vld = 0; cfg_src = 2'd0; cfg_falling = 0; sw_trig = 0; rearm();
        smp_vld = 1; step(); sw_trig = 1; step(); smp_vld = 0; steps(2);
        chk("R7", "drive held", sync_drive_low, 1);
        chk("R7", "no pulse without valid", npulse, 0);
        arm = 0; step();
        chk("R7", "drive dropped on disarm", sync_drive_low, 0);

        // R9: follower does not drive, fires on line
        req = "R9"; cfg_follow = 1; cfg_src = 2'd2; cfg_falling = 1; rearm();
        adc_smp_put(0); adc_smp_put(-600); steps(2);
        chk("R9", "follower local event ignored", npulse, 0);
        smp_vld = 0; peer_low = 1; steps(2);
        chk("R9", "line without valid sample", npulse, 0);
        smp_vld = 1; step(); step(); peer_low = 0;
        chk("R9", "follower fires from line", npulse, 1);

        // R8: leader fires from a peer pulling the line
        req = "R8"; cfg_follow = 0; rearm();
        peer_low = 1; smp_vld = 1; step(); step(); peer_low = 0; steps(2);
        chk("R8", "leader fires from peer", npulse, 1);

        // R10: unarmed unit ignores everything
        req = "R10"; arm = 0; cfg_src = 2'd0; cfg_falling = 0; steps(2); npulse = 0;
        sw_trig = 0; step(); sw_trig = 1; step(); peer_low = 1; steps(3); peer_low = 0;
        chk("R10", "no pulse unarmed", npulse, 0);
        chk("R10", "no drive unarmed", sync_drive_low, 0);

        finish_run();
    end
endmodule